// File: doc/BRIEF.md
# Bus-to-DMA Window Address Translator

This block converts an address arriving from a peripheral bus into a system memory address for DMA. Four windows are programmed from outside through a base register, a mask register and a translated-base register per window, each 64 bits wide and presented to the block as flat input vectors. A request carries one bus address. The block finds the lowest-numbered window that both covers the address and is switched on, and then builds the result in one of two ways. A window in direct mode splices bits of the translated base with bits of the bus address. A window in scatter-gather mode first reads one 64-bit page-table entry through a memory read port and then forms the result from that entry.

An address that no enabled window covers comes back unchanged. While a page-table read is outstanding the block accepts no request, so at most one translation is in flight. Results appear as a single-cycle valid pulse with the address.

Top module: `dma_window_xlate`

## Requirements
- R1: After reset, `rsp_valid` and `mem_req` are 0 and `req_ready` is 1.
- R2: A window covers an address when the address and the window's base agree on every bit in 31:20 whose mask bit is 0. Mask bits that are 1 and all bits outside 31:20 do not affect the match.
- R3: Windows are tried from index 0 upward and the first one that covers the address wins. A window whose base bit 0 (enable) is 0 never wins, and the search moves on to the next index.
- R4: With base bit 1 equal to 0 (direct mode), let P be the mask's bits 31:20 together with bits 19:0. The result takes the bits inside P from the bus address and every other bit from the translated base.
- R5: With base bit 1 equal to 1 (scatter-gather mode), `mem_req` rises one cycle after acceptance and stays high, with `mem_addr` unchanged, until the cycle in which `mem_rvalid` is sampled high. `mem_addr` is the translated base with bits cleared wherever (mask bits 31:20 shifted right by 10) or bits 9:0 are set, ORed with (bus address AND (mask bits 31:20 OR bits 19:13)) shifted right by 10.
- R6: The scatter-gather result is the fetched entry with bit 0 cleared, shifted left by 12, ORed with bits 12:0 of the bus address.
- R7: Every result that came through a window has bits 63:34 equal to 0.
- R8: When no window wins, the result equals the full 64-bit bus address.
- R9: A direct or unmatched result is presented one cycle after acceptance, and a scatter-gather result one cycle after `mem_rvalid` is sampled. `rsp_valid` is high only in those cycles.
- R10: `req_ready` is 0 from the cycle after a scatter-gather acceptance until the entry arrives. A request held during that time is not taken and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus address is presented |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 64 | Bus address to translate |
| win_base | input | 256 | Base registers of windows 0..3 (window i at bits 64i+63:64i) |
| win_mask | input | 256 | Mask registers of windows 0..3 |
| win_tbase | input | 256 | Translated-base registers of windows 0..3 |
| rsp_valid | output | 1 | Translated address is valid this cycle |
| rsp_addr | output | 64 | Translated address |
| mem_req | output | 1 | Page-table entry read is requested |
| mem_addr | output | 64 | Page-table entry address |
| mem_rvalid | input | 1 | Entry data is valid this cycle |
| mem_rdata | input | 64 | Page-table entry |

## Verification
The assertions rely on the memory side raising `mem_rvalid` only while `mem_req` is high, and on the window vectors holding steady through any cycle in which a request is accepted. The stimulus meets both conditions. A responder answers only an outstanding entry read, after a random delay of zero to four cycles, and window contents are changed only when no request is in flight. Held requests during a fetch, back-to-back requests, overlapping windows, disabled windows and addresses with high bits set are all produced on purpose.

// File: rtl/dwx_pkg.sv
package dwx_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } dwx_state_e;

    typedef enum logic [1:0] {
        MAP_PASS   = 2'd0,
        MAP_DIRECT = 2'd1,
        MAP_SG     = 2'd2
    } dwx_map_e;

endpackage

// File: rtl/dwx_window_match.sv
// Decides whether one window covers an address and is switched on.
module dwx_window_match #(
    parameter int ADDR_W = 64,
    parameter int CMP_LO = 20,
    parameter int CMP_HI = 31,
    parameter int EN_BIT = 0,
    parameter int SG_BIT = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    output logic              hit,
    output logic              sg
);
    localparam int FW = CMP_HI - CMP_LO + 1;

    logic [FW-1:0] diff_field;
    logic [FW-1:0] care_field;

    always_comb begin
        diff_field = addr[CMP_HI:CMP_LO] ^ base[CMP_HI:CMP_LO];
        care_field = ~mask[CMP_HI:CMP_LO];
        hit        = base[EN_BIT] && ((diff_field & care_field) == '0);
        sg         = base[SG_BIT];
    end
endmodule

// File: rtl/dwx_first_hit.sv
// Fixed priority: lowest index wins.
module dwx_first_hit #(
    parameter int NUM_WIN = 4
) (
    input  logic [NUM_WIN-1:0] hits,
    output logic [NUM_WIN-1:0] grant,
    output logic               any_hit
);
    always_comb begin
        grant   = '0;
        any_hit = 1'b0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (hits[i] && !any_hit) begin
                grant[i] = 1'b1;
                any_hit  = 1'b1;
            end
        end
    end

    always_comb begin
        p_grant_onehot_r3: assert ($onehot0(grant));
    end
endmodule

// File: rtl/dwx_addr_calc.sv
// Address arithmetic for the selected window.
module dwx_addr_calc #(
    parameter int ADDR_W     = 64,
    parameter int CMP_LO     = 20,
    parameter int CMP_HI     = 31,
    parameter int IDX_LO     = 13,
    parameter int PTE_SHIFT  = 10,
    parameter int PAGE_SHIFT = 12,
    parameter int OUT_W      = 34
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] sel_mask,
    input  logic [ADDR_W-1:0] sel_tbase,
    input  logic [ADDR_W-1:0] held_addr,
    input  logic [ADDR_W-1:0] entry,
    output logic [ADDR_W-1:0] direct_addr,
    output logic [ADDR_W-1:0] pte_addr,
    output logic [ADDR_W-1:0] sg_addr
);
    localparam logic [ADDR_W-1:0] ONES      = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] CMP_FIELD = (ONES >> (ADDR_W - (CMP_HI - CMP_LO + 1))) << CMP_LO;
    localparam logic [ADDR_W-1:0] LOW_PASS  = ONES >> (ADDR_W - CMP_LO);
    localparam logic [ADDR_W-1:0] PTE_LOW   = ONES >> (ADDR_W - PTE_SHIFT);
    localparam logic [ADDR_W-1:0] IDX_FIELD = (ONES >> (ADDR_W - (CMP_LO - IDX_LO))) << IDX_LO;
    localparam logic [ADDR_W-1:0] PG_OFF    = ONES >> (ADDR_W - IDX_LO);
    localparam logic [ADDR_W-1:0] OUT_MASK  = ONES >> (ADDR_W - OUT_W);

    logic [ADDR_W-1:0] mfield;
    logic [ADDR_W-1:0] pass_mask;
    logic [ADDR_W-1:0] tb_keep;
    logic [ADDR_W-1:0] idx_bits;
    logic [ADDR_W-1:0] frame;

    always_comb begin
        mfield      = sel_mask & CMP_FIELD;
        pass_mask   = mfield | LOW_PASS;
        direct_addr = ((sel_tbase & ~pass_mask) | (bus_addr & pass_mask)) & OUT_MASK;

        tb_keep     = ~((mfield >> PTE_SHIFT) | PTE_LOW);
        idx_bits    = (bus_addr & (mfield | IDX_FIELD)) >> PTE_SHIFT;
        pte_addr    = (sel_tbase & tb_keep) | idx_bits;

        frame       = (entry & ~ADDR_W'(1)) << PAGE_SHIFT;
        sg_addr     = (frame | (held_addr & PG_OFF)) & OUT_MASK;
    end
endmodule

// File: rtl/dma_window_xlate.sv
module dma_window_xlate
    import dwx_pkg::*;
#(
    parameter int NUM_WIN    = 4,
    parameter int ADDR_W     = 64,
    parameter int CMP_LO     = 20,
    parameter int CMP_HI     = 31,
    parameter int IDX_LO     = 13,
    parameter int PTE_SHIFT  = 10,
    parameter int PAGE_SHIFT = 12,
    parameter int OUT_W      = 34
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [NUM_WIN*ADDR_W-1:0] win_base,
    input  logic [NUM_WIN*ADDR_W-1:0] win_mask,
    input  logic [NUM_WIN*ADDR_W-1:0] win_tbase,
    output logic                      rsp_valid,
    output logic [ADDR_W-1:0]         rsp_addr,
    output logic                      mem_req,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic                      mem_rvalid,
    input  logic [ADDR_W-1:0]         mem_rdata
);
    typedef struct packed {
        dwx_state_e          fsm;
        logic                rsp_v;
        dwx_map_e            rsp_kind;
        logic [ADDR_W-1:0]   rsp_addr;
        logic [ADDR_W-1:0]   held_addr;
        logic [ADDR_W-1:0]   pte_addr;
    } xl_state_t;

    xl_state_t st_d, st_q;

    logic [NUM_WIN-1:0] win_hit;
    logic [NUM_WIN-1:0] win_sg;
    logic [NUM_WIN-1:0] grant;
    logic               any_hit;
    logic               sel_sg;
    logic [ADDR_W-1:0]  sel_mask;
    logic [ADDR_W-1:0]  sel_tbase;
    logic [ADDR_W-1:0]  direct_addr;
    logic [ADDR_W-1:0]  pte_addr;
    logic [ADDR_W-1:0]  sg_addr;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        dwx_window_match #(
            .ADDR_W (ADDR_W),
            .CMP_LO (CMP_LO),
            .CMP_HI (CMP_HI)
        ) u_match (
            .addr (req_addr),
            .base (win_base[w*ADDR_W +: ADDR_W]),
            .mask (win_mask[w*ADDR_W +: ADDR_W]),
            .hit  (win_hit[w]),
            .sg   (win_sg[w])
        );
    end

    dwx_first_hit #(.NUM_WIN(NUM_WIN)) u_prio (
        .hits    (win_hit),
        .grant   (grant),
        .any_hit (any_hit)
    );

    always_comb begin
        sel_mask  = '0;
        sel_tbase = '0;
        sel_sg    = 1'b0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (grant[i]) begin
                sel_mask  = win_mask[i*ADDR_W +: ADDR_W];
                sel_tbase = win_tbase[i*ADDR_W +: ADDR_W];
                sel_sg    = win_sg[i];
            end
        end
    end

    dwx_addr_calc #(
        .ADDR_W     (ADDR_W),
        .CMP_LO     (CMP_LO),
        .CMP_HI     (CMP_HI),
        .IDX_LO     (IDX_LO),
        .PTE_SHIFT  (PTE_SHIFT),
        .PAGE_SHIFT (PAGE_SHIFT),
        .OUT_W      (OUT_W)
    ) u_calc (
        .bus_addr    (req_addr),
        .sel_mask    (sel_mask),
        .sel_tbase   (sel_tbase),
        .held_addr   (st_q.held_addr),
        .entry       (mem_rdata),
        .direct_addr (direct_addr),
        .pte_addr    (pte_addr),
        .sg_addr     (sg_addr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = 1'b0;
        unique case (st_q.fsm)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!any_hit) begin
                        st_d.rsp_v    = 1'b1;
                        st_d.rsp_kind = MAP_PASS;
                        st_d.rsp_addr = req_addr;
                    end else if (sel_sg) begin
                        st_d.fsm       = ST_FETCH;
                        st_d.held_addr = req_addr;
                        st_d.pte_addr  = pte_addr;
                    end else begin
                        st_d.rsp_v    = 1'b1;
                        st_d.rsp_kind = MAP_DIRECT;
                        st_d.rsp_addr = direct_addr;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_rvalid) begin
                    st_d.fsm      = ST_IDLE;
                    st_d.rsp_v    = 1'b1;
                    st_d.rsp_kind = MAP_SG;
                    st_d.rsp_addr = sg_addr;
                end
            end
            default: st_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fsm: ST_IDLE, rsp_v: 1'b0, rsp_kind: MAP_PASS,
                      rsp_addr: '0, held_addr: '0, pte_addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.fsm == ST_IDLE);
    assign mem_req   = (st_q.fsm == ST_FETCH);
    assign mem_addr  = st_q.pte_addr;
    assign rsp_valid = st_q.rsp_v;
    assign rsp_addr  = st_q.rsp_addr;

    p_memaddr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req) && !$past(mem_rvalid)) |-> $stable(mem_addr));

    p_fetch_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |=> (!mem_req && rsp_valid));

    p_rsp_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_req && mem_rvalid)));

    p_trunc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && st_q.rsp_kind != MAP_PASS) |-> (rsp_addr[ADDR_W-1:OUT_W] == '0));

    p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !any_hit) |=> (rsp_valid && rsp_addr == $past(req_addr)));

    p_busy_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && any_hit && sel_sg) |=> (mem_req && !req_ready && !rsp_valid));
endmodule

// File: tb/dma_window_xlate_tb.sv
module dma_window_xlate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam logic [63:0] FLD  = 64'h0000_0000_FFF0_0000;
    localparam logic [63:0] TRUN = 64'h0000_0003_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [63:0] rsp_addr;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    logic [63:0] wb [4] = '{default: '0};
    logic [63:0] wm [4] = '{default: '0};
    logic [63:0] wt [4] = '{default: '0};

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int lat_cnt = 0;
    bit done    = 1'b0;

    bit          m_busy  = 1'b0;
    bit          m_rsp_v = 1'b0;
    logic [63:0] m_rsp_a = '0;
    logic [63:0] m_pte   = '0;
    logic [63:0] m_held  = '0;
    string       m_tag   = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_window_xlate u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .win_base   ({wb[3], wb[2], wb[1], wb[0]}),
        .win_mask   ({wm[3], wm[2], wm[1], wm[0]}),
        .win_tbase  ({wt[3], wt[2], wt[1], wt[0]}),
        .rsp_valid  (rsp_valid),
        .rsp_addr   (rsp_addr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    function automatic logic [63:0] entry_of(input logic [63:0] a);
        return (a * 64'h9E37_79B9_7F4A_7C15) ^ 64'h1;
    endfunction

    // Behavioural reading of R2..R8: kind 0 pass, 1 direct, 2 scatter-gather.
    function automatic void spec(input logic [63:0] a, output int kind,
                                 output logic [63:0] res, output logic [63:0] pte);
        logic [63:0] cmp, pm, tk, bm;
        kind = 0; res = a; pte = '0;
        for (int w = 0; w < 4; w++) begin
            cmp = ~wm[w] & FLD;
            if (kind == 0 && (a & cmp) == (wb[w] & cmp) && wb[w][0]) begin
                if (wb[w][1]) begin
                    kind = 2;
                    tk   = ~(((wm[w] & FLD) >> 10) | 64'h3FF);
                    bm   = (wm[w] & FLD) | (64'h7F << 13);
                    pte  = (wt[w] & tk) | ((a & bm) >> 10);
                end else begin
                    kind = 1;
                    pm   = (wm[w] & FLD) | 64'hF_FFFF;
                    res  = ((wt[w] & ~pm) | (a & pm)) & TRUN;
                end
            end
        end
    endfunction

    // Reference model, advanced on each rising edge from the driven inputs.
    always @(posedge clk) begin
        int          k;
        logic [63:0] r, p;
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_rsp_v = 0;
        end else begin
            m_rsp_v = 0;
            if (!m_busy) begin
                if (req_valid) begin
                    spec(req_addr, k, r, p);
                    if (k == 2) begin
                        m_busy = 1; m_pte = p; m_held = req_addr;
                    end else begin
                        m_rsp_v = 1; m_rsp_a = r;
                        m_tag = (k == 1) ? "R2 R3 R4 R7" : "R8";
                    end
                end
            end else if (mem_rvalid) begin
                m_busy  = 0;
                m_rsp_v = 1;
                m_rsp_a = ((((mem_rdata & ~64'h1) << 12)) | (m_held & 64'h1FFF)) & TRUN;
                m_tag   = "R6 R7";
            end
        end
        if (cyc > WATCHDOG && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run did not finish by cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // Every-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(rsp_valid === m_rsp_v, "R9", 64'(rsp_valid), 64'(m_rsp_v));
            if (m_rsp_v) chk(rsp_addr === m_rsp_a, m_tag, rsp_addr, m_rsp_a);
            chk(req_ready === !m_busy, "R10", 64'(req_ready), 64'(!m_busy));
            chk(mem_req === m_busy, "R5", 64'(mem_req), 64'(m_busy));
            if (m_busy) chk(mem_addr === m_pte, "R5", mem_addr, m_pte);
        end
    end

    // Memory responder: answers only an outstanding read, after 0..4 cycles.
    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            mem_rdata  = 64'hDEAD_BEEF_0BAD_F00D;
        end else if (mem_req === 1'b1) begin
            if (lat_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = entry_of(mem_addr);
                lat_cnt    = $urandom_range(0, 4);
            end else begin
                lat_cnt--;
            end
        end
    end

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic send(input logic [63:0] a, input bit hold);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        if (hold && !req_ready) begin
            req_addr = ~a;                 // R10: must be ignored while fetching
            while (!req_ready) @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(rsp_valid === 1'b0 && mem_req === 1'b0 && req_ready === 1'b1, "R1",
            {61'b0, rsp_valid, mem_req, req_ready}, 64'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid === 1'b0 && mem_req === 1'b0 && req_ready === 1'b1, "R1",
            {61'b0, rsp_valid, mem_req, req_ready}, 64'h1);

        // R8: no window enabled at all.
        send(64'hFFFF_0000_1234_5678, 0);
        send(64'h0, 0);
        drain();

        // W0 covers but is disabled (R3); W1 direct with high tbase bits (R4, R7);
        // W2 scatter-gather (R5, R6); W3 overlaps W1 at lower priority (R2, R3).
        wb[0] = 64'h1000_0000;           wm[0] = 64'h0FF0_0000; wt[0] = 64'h2_0000_0000;
        wb[1] = 64'h1000_0001;           wm[1] = 64'h00F0_0000; wt[1] = 64'hFFFF_FFFF_A000_0000;
        wb[2] = 64'h2000_0003;           wm[2] = 64'h0030_0000; wt[2] = 64'h0000_0000_0123_4C00;
        wb[3] = 64'h1000_0001;           wm[3] = 64'h0FF0_0000; wt[3] = 64'h3_8000_0000;
        @(negedge clk);
        send(64'h1012_3456, 0);          // W1 direct
        send(64'h1812_3456, 0);          // W3 (W1 mask does not cover bit 27)
        send(64'hABCD_0000_10F0_0001, 0);// high bits outside 31:20 ignored
        send(64'h3012_3456, 0);          // pass-through
        send(64'h2012_3456, 0);          // scatter-gather
        send(64'h2034_5678, 1);          // scatter-gather with held request
        send(64'h2040_0000, 0);          // outside W2 -> pass
        drain();

        // R3: enabling W0 lets it take precedence over W1 and W3.
        wb[0] = 64'h1000_0001;
        @(negedge clk);
        send(64'h1012_3456, 0);
        send(64'h1812_3456, 0);
        drain();

        // Random traffic across windows, latencies and held requests.
        for (int n = 0; n < 400; n++) begin
            logic [63:0] a;
            if (n % 50 == 0) begin
                drain();
                for (int w = 0; w < 4; w++) begin
                    wb[w] = {32'h0, $urandom_range(0, 3) << 28, 26'h0, 2'($urandom_range(0, 3))};
                    wm[w] = {32'h0, 12'($urandom()), 20'h0} & 64'h0FF0_0000;
                    wt[w] = {$urandom(), $urandom()};
                end
                @(negedge clk);
            end
            a = {$urandom(), $urandom_range(0, 3) << 28 | ($urandom() & 32'h0FFF_FFFF)};
            send(a, ($urandom_range(0, 3) == 0));
        end
        drain();
        repeat (4) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule